// File: doc/BRIEF.md
# Walsh Spectrum Bit-Stream Analyzer

This block takes a serial bit-stream of fixed length (128 samples by default) from one circuit input and works out its Walsh spectrum. Each accepted bit becomes a signed sample: logic 0 becomes -1 and logic 1 becomes +1. The stream is then correlated with every Walsh basis function by an in-place fast Walsh-Hadamard transform. The transform uses only additions and subtractions and works on a buffer of signed words.

Once the transform has finished, the block streams out every spectral coefficient in ascending index order, one per cycle. Each coefficient carries a flag that says whether it is essential or noise. A coefficient is essential when its normalized power c²/N² is above the noise floor of a random stream, 1/N. The block tests this as the integer comparison c² > N, so it needs no divider and no multiplier.

A user pulses `start`, feeds bits qualified by `bit_valid`, collects the coefficient stream, and waits for the `done` pulse before starting the next analysis.

Top module: `wsa_spectrum_top`

## Requirements
- R1: Collection begins only on a `start` seen while the block is idle. `bit_valid` before that start, or in the same cycle as that start, stores nothing. A `start` while a collection, transform or output burst is in progress has no effect.
- R2: The n-th bit accepted after start (n = 0..127) becomes sample x[n]: -1 for logic 0 and +1 for logic 1.
- R3: The coefficient with index k equals the sum over n of x[n]·(-1)^popcount(k AND n). This is the natural Hadamard ordering: row 0 is all ones, row 1 changes sign every sample, and row 2 changes sign every two samples.
- R4: Once 128 bits have been accepted, further `bit_valid` bits are ignored until the next start.
- R5: `coef_essential` is 1 exactly when coef_val² > 128, which means |coef_val| ≥ 12.
- R6: The first coefficient appears 448 clock edges after the edge that accepts the 128th bit. `coef_valid` then stays high for 128 consecutive cycles, while `coef_idx` counts 0, 1, …, 127.
- R7: `done` is high for exactly one cycle, in the cycle after the coefficient with index 127. The block is idle and accepts `start` from the next edge on.
- R8: While reset is active, and after it is released until a start, `coef_valid`, `coef_essential`, `done`, `coef_idx` and `coef_val` are all 0.
- R9: An all-zero stream gives coefficient 0 = -128, flagged essential, and every other coefficient 0 and flagged noise.
- R10: No intermediate butterfly result exceeds the signed 9-bit word range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin collecting a stream |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial stream bit |
| coef_valid | output | 1 | A coefficient is presented this cycle |
| coef_idx | output | 7 | Walsh row index of the presented coefficient |
| coef_val | output | 9 | Signed coefficient value |
| coef_essential | output | 1 | 1 when the coefficient is essential, 0 when it is noise |
| done | output | 1 | One-cycle pulse after the last coefficient |

## Verification
The stream is applied in several forms:
- An all-zero stream and an all-one stream. These put all the energy into row 0 with opposite signs, which separates the sign mapping from the correlation.
- Three streams that each match exactly one Walsh row: rows 1, 2 and 5. Each must produce a single ±128 coefficient at the right index, so they expose any butterfly pairing or pass-order fault.
- Random streams, fed with gaps in `bit_valid`, with surplus bits after the 128th, and with `start` pulses while the block is busy. These spread energy over many rows, which exercises the essential threshold near |c| = 12. They also show whether stray bits or starts disturb a result.

A behavioural model advances each cycle and predicts when every coefficient and `done` pulse appears. It computes each coefficient as a direct matrix-vector product.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_XFORM,
    ST_EMIT,
    ST_DONE
  } wsa_state_e;

  // Largest integer r with r*r <= v, evaluated at elaboration time.
  function automatic int unsigned isqrt_floor(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((r + 1) * (r + 1) <= v) r = r + 1;
    return r;
  endfunction

endpackage

// File: rtl/wsa_sample_buf.sv
module wsa_sample_buf #(
  parameter int N  = 128,
  parameter int W  = 9,
  parameter int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                we_a,
  input  logic [AW-1:0]       addr_a,
  input  logic signed [W-1:0] wdata_a,
  input  logic                we_b,
  input  logic [AW-1:0]       addr_b,
  input  logic signed [W-1:0] wdata_b,
  output logic signed [W-1:0] rdata_a,
  output logic signed [W-1:0] rdata_b
);

  logic signed [W-1:0] mem_q [N];

  // Storage array: per-entry clock enable, no reset (contents are always
  // written during collection before any read).
  for (genvar e = 0; e < N; e++) begin : g_entry
    logic                hit_a;
    logic                hit_b;
    logic                ent_en;
    logic signed [W-1:0] ent_d;

    always_comb begin
      hit_a  = we_a && (addr_a == AW'(e));
      hit_b  = we_b && (addr_b == AW'(e));
      ent_en = hit_a || hit_b;
      ent_d  = hit_a ? wdata_a : wdata_b;
    end

    always_ff @(posedge clk) begin
      if (ent_en) mem_q[e] <= ent_d;
    end
  end

  assign rdata_a = mem_q[addr_a];
  assign rdata_b = mem_q[addr_b];

endmodule

// File: rtl/wsa_butterfly.sv
module wsa_butterfly #(
  parameter int W = 9
) (
  input  logic                en_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] sum_o,
  output logic signed [W-1:0] diff_o
);

  logic signed [W:0] wide_sum;
  logic signed [W:0] wide_diff;

  always_comb begin
    wide_sum  = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    wide_diff = {a_i[W-1], a_i} - {b_i[W-1], b_i};
    sum_o     = wide_sum[W-1:0];
    diff_o    = wide_diff[W-1:0];
  end

  always_comb begin
    if (en_i) begin
      AST_NO_OVERFLOW: assert ((wide_sum[W] == wide_sum[W-1]) && (wide_diff[W] == wide_diff[W-1])); // R10
    end
  end

endmodule

// File: rtl/wsa_power_cmp.sv
module wsa_power_cmp #(
  parameter int N = 128,
  parameter int W = 9
) (
  input  logic signed [W-1:0] coef_i,
  output logic                essential_o
);

  import wsa_pkg::*;

  // c*c > N  <=>  |c| > floor(sqrt(N)) for integer c
  localparam int unsigned THR = isqrt_floor(N);

  logic signed [W:0] coef_ext;
  logic [W:0]        mag;

  always_comb begin
    coef_ext    = {coef_i[W-1], coef_i};
    mag         = coef_i[W-1] ? (W+1)'(-coef_ext) : (W+1)'(coef_ext);
    essential_o = (mag > (W+1)'(THR));
  end

endmodule

// File: rtl/wsa_seq.sv
module wsa_seq #(
  parameter int N  = 128,
  parameter int W  = 9,
  parameter int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                bit_valid_i,
  input  logic                bit_i,
  input  logic signed [W-1:0] bfly_sum_i,
  input  logic signed [W-1:0] bfly_diff_i,
  output logic                we_a_o,
  output logic [AW-1:0]       addr_a_o,
  output logic signed [W-1:0] wdata_a_o,
  output logic                we_b_o,
  output logic [AW-1:0]       addr_b_o,
  output logic signed [W-1:0] wdata_b_o,
  output logic                bfly_en_o,
  output logic                emit_o,
  output logic [AW-1:0]       emit_idx_o,
  output logic                done_o
);

  import wsa_pkg::*;

  localparam int PASSES = AW;
  localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [AW-1:0] LAST_IDX  = AW'(N - 1);
  localparam logic [AW-2:0] LAST_PAIR = (AW-1)'(N/2 - 1);
  localparam logic [PW-1:0] LAST_PASS = PW'(PASSES - 1);

  wsa_state_e      state_q, state_d;
  logic [AW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;
  logic [PW-1:0]   pass_q, pass_d;
  logic            pass_en;

  logic [AW-2:0]   pair;
  logic [AW-1:0]   pair_lo;
  logic [AW-1:0]   pair_up;
  logic [AW-1:0]   idx_lo;
  logic [AW-1:0]   idx_hi;

  // Butterfly pair addresses: insert a 0 at bit position pass_q into the
  // pair counter for the lower index; the partner sits 2**pass_q above.
  always_comb begin
    pair    = cnt_q[AW-2:0];
    pair_lo = {1'b0, pair};
    pair_up = {pair, 1'b0};
    for (int b = 0; b < AW; b++) begin
      if (PW'(b) < pass_q)       idx_lo[b] = pair_lo[b];
      else if (PW'(b) == pass_q) idx_lo[b] = 1'b0;
      else                       idx_lo[b] = pair_up[b];
    end
    idx_hi = idx_lo | (AW'(1) << pass_q);
  end

  // Next-state and datapath control
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    pass_d    = pass_q;
    pass_en   = 1'b0;
    we_a_o    = 1'b0;
    we_b_o    = 1'b0;
    addr_a_o  = cnt_q;
    addr_b_o  = idx_hi;
    wdata_a_o = bfly_sum_i;
    wdata_b_o = bfly_diff_i;
    bfly_en_o = 1'b0;
    emit_o    = 1'b0;
    done_o    = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FILL;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end

      ST_FILL: begin
        addr_a_o  = cnt_q;
        wdata_a_o = bit_i ? W'(1) : {W{1'b1}};
        if (bit_valid_i) begin
          we_a_o = 1'b1;
          cnt_en = 1'b1;
          cnt_d  = cnt_q + AW'(1);
          if (cnt_q == LAST_IDX) begin
            state_d = ST_XFORM;
            cnt_d   = '0;
            pass_d  = '0;
            pass_en = 1'b1;
          end
        end
      end

      ST_XFORM: begin
        addr_a_o  = idx_lo;
        addr_b_o  = idx_hi;
        bfly_en_o = 1'b1;
        we_a_o    = 1'b1;
        we_b_o    = 1'b1;
        cnt_en    = 1'b1;
        if (pair == LAST_PAIR) begin
          cnt_d   = '0;
          pass_en = 1'b1;
          if (pass_q == LAST_PASS) begin
            state_d = ST_EMIT;
            pass_d  = '0;
          end else begin
            pass_d  = pass_q + PW'(1);
          end
        end else begin
          cnt_d = cnt_q + AW'(1);
        end
      end

      ST_EMIT: begin
        addr_a_o = cnt_q;
        emit_o   = 1'b1;
        cnt_en   = 1'b1;
        cnt_d    = cnt_q + AW'(1);
        if (cnt_q == LAST_IDX) state_d = ST_DONE;
      end

      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end

      default: state_d = ST_IDLE;
    endcase
  end

  assign emit_idx_o = cnt_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= '0;
    end else if (pass_en) begin
      pass_q <= pass_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE)); // R1

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFORM && start_i) |=> (state_q != ST_FILL)); // R1

  AST_FULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EMIT) |=> (state_q != ST_FILL)); // R4

endmodule

// File: rtl/wsa_spectrum_top.sv
module wsa_spectrum_top #(
  parameter int N  = 128,
  parameter int AW = $clog2(N),
  parameter int W  = AW + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                bit_valid,
  input  logic                bit_in,
  output logic                coef_valid,
  output logic [AW-1:0]       coef_idx,
  output logic signed [W-1:0] coef_val,
  output logic                coef_essential,
  output logic                done
);

  logic [1:0]          rst_sync_q;
  logic                rst_n_int;

  logic                we_a, we_b;
  logic [AW-1:0]       addr_a, addr_b;
  logic signed [W-1:0] wdata_a, wdata_b;
  logic signed [W-1:0] rdata_a, rdata_b;
  logic signed [W-1:0] bfly_sum, bfly_diff;
  logic                bfly_en;
  logic                emit;
  logic [AW-1:0]       emit_idx;
  logic                done_int;
  logic                ess_raw;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  wsa_seq #(.N(N), .W(W), .AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_i     (start),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_in),
    .bfly_sum_i  (bfly_sum),
    .bfly_diff_i (bfly_diff),
    .we_a_o      (we_a),
    .addr_a_o    (addr_a),
    .wdata_a_o   (wdata_a),
    .we_b_o      (we_b),
    .addr_b_o    (addr_b),
    .wdata_b_o   (wdata_b),
    .bfly_en_o   (bfly_en),
    .emit_o      (emit),
    .emit_idx_o  (emit_idx),
    .done_o      (done_int)
  );

  wsa_sample_buf #(.N(N), .W(W), .AW(AW)) u_buf (
    .clk     (clk),
    .we_a    (we_a),
    .addr_a  (addr_a),
    .wdata_a (wdata_a),
    .we_b    (we_b),
    .addr_b  (addr_b),
    .wdata_b (wdata_b),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b)
  );

  wsa_butterfly #(.W(W)) u_bfly (
    .en_i   (bfly_en),
    .a_i    (rdata_a),
    .b_i    (rdata_b),
    .sum_o  (bfly_sum),
    .diff_o (bfly_diff)
  );

  wsa_power_cmp #(.N(N), .W(W)) u_cmp (
    .coef_i      (rdata_a),
    .essential_o (ess_raw)
  );

  always_comb begin
    coef_valid     = emit;
    coef_idx       = emit ? emit_idx : '0;
    coef_val       = emit ? rdata_a : '0;
    coef_essential = emit && ess_raw;
    done           = done_int;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |=> !done); // R7

  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (coef_valid && coef_idx == AW'(N - 1)) |=> (done && !coef_valid)); // R7

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (coef_valid && coef_idx != AW'(N - 1)) |=> (coef_valid && coef_idx == $past(coef_idx) + AW'(1))); // R6

  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(coef_valid) |-> (coef_idx == '0)); // R6

  AST_NOISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    !coef_valid |-> (!coef_essential && coef_val == '0)); // R8

endmodule

// File: tb/wsa_spectrum_top_tb_top.sv
`timescale 1ns/1ps
module wsa_spectrum_top_tb_top;

  localparam int N      = 128;
  localparam int XF_CYC = 448;
  localparam real HALF  = 10.0;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              bit_valid;
  logic              bit_in;
  logic              coef_valid;
  logic [6:0]        coef_idx;
  logic signed [8:0] coef_val;
  logic              coef_essential;
  logic              done;

  int checks;
  int errors;
  int ess_seen;
  int done_seen;

  // reference model state
  int m_phase; // 0 idle, 1 fill, 2 transform, 3 output, 4 done
  int m_cnt;
  int m_wait;
  int m_idx;
  int m_bits [N];
  int m_coef [N];

  logic stim [N];

  wsa_spectrum_top dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .bit_valid      (bit_valid),
    .bit_in         (bit_in),
    .coef_valid     (coef_valid),
    .coef_idx       (coef_idx),
    .coef_val       (coef_val),
    .coef_essential (coef_essential),
    .done           (done)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  // direct matrix-vector product, R2/R3
  task automatic compute_spectrum();
    for (int k = 0; k < N; k++) begin
      int acc;
      acc = 0;
      for (int n = 0; n < N; n++) begin
        int x;
        x = (m_bits[n] != 0) ? 1 : -1;
        if (($countones(k & n) % 2) == 1) acc = acc - x;
        else acc = acc + x;
      end
      m_coef[k] = acc;
    end
  endtask

  // cycle-by-cycle behavioural model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_wait = 0; m_idx = 0;
    end else begin
      case (m_phase)
        0: if (start) begin m_phase = 1; m_cnt = 0; end
        1: if (bit_valid) begin
             m_bits[m_cnt] = bit_in ? 1 : 0;
             m_cnt = m_cnt + 1;
             if (m_cnt == N) begin m_phase = 2; m_wait = 0; end
           end
        2: begin
             m_wait = m_wait + 1;
             if (m_wait == XF_CYC) begin
               compute_spectrum();
               m_phase = 3; m_idx = 0;
             end
           end
        3: begin
             m_idx = m_idx + 1;
             if (m_idx == N) m_phase = 4;
           end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(coef_valid == (m_phase == 3), "R6", "coef_valid", coef_valid, m_phase == 3);
      check(done == (m_phase == 4), "R7", "done", done, m_phase == 4);
      if (done) done_seen++;
      if (m_phase == 3 && coef_valid) begin
        check(coef_idx == m_idx[6:0], "R6", "coef_idx", coef_idx, m_idx);
        check(int'(coef_val) == m_coef[m_idx], "R3", "coef_val", int'(coef_val), m_coef[m_idx]);
        check(coef_essential == (m_coef[m_idx] * m_coef[m_idx] > N), "R5",
              "coef_essential", coef_essential, m_coef[m_idx] * m_coef[m_idx] > N);
        if (coef_essential) ess_seen++;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // gap_mode: insert idle cycles; extra: surplus bits after the 128th;
  // stray: pulse start while the transform runs
  task automatic run_stream(input bit gap_mode, input int extra, input bit stray);
    int guard;
    int d0;
    ess_seen = 0;
    d0 = done_seen;
    // R1: bits before start are not stored
    for (int i = 0; i < 3; i++) begin
      tick(); bit_valid = 1'b1; bit_in = ~stim[i];
    end
    // R1: bit in the same cycle as start is not stored
    tick(); start = 1'b1; bit_valid = 1'b1; bit_in = ~stim[0];
    for (int n = 0; n < N; n++) begin
      if (gap_mode && (n % 3 == 2)) begin
        tick(); start = 1'b0; bit_valid = 1'b0; bit_in = ~stim[n];
      end
      tick(); start = 1'b0; bit_valid = 1'b1; bit_in = stim[n];
    end
    // R4: surplus bits ignored
    for (int i = 0; i < extra; i++) begin
      tick(); bit_valid = 1'b1; bit_in = $urandom_range(0, 1);
    end
    tick(); bit_valid = 1'b0;
    if (stray) begin
      for (int i = 0; i < 10; i++) tick();
      start = 1'b1; // R1: start while busy
      tick(); start = 1'b0;
    end
    guard = 0;
    while (done_seen == d0 && guard < 2000) begin
      tick(); guard++;
    end
    check(guard < 2000, "R7", "watchdog waiting for done", guard, 0);
    tick(); tick();
  endtask

  initial begin
    checks = 0; errors = 0; ess_seen = 0; done_seen = 0;
    start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R8: reset state
    check(coef_valid == 1'b0, "R8", "coef_valid in reset", coef_valid, 0);
    check(done == 1'b0, "R8", "done in reset", done, 0);
    check(coef_essential == 1'b0, "R8", "coef_essential in reset", coef_essential, 0);
    check(coef_val == '0 && coef_idx == '0, "R8", "coef_val/idx in reset", int'(coef_val), 0);
    tick(); rst_n = 1'b1;
    repeat (4) tick();
    check(coef_valid == 1'b0 && done == 1'b0, "R8", "idle after reset", coef_valid, 0);

    // all-zero stream, R9
    for (int n = 0; n < N; n++) stim[n] = 1'b0;
    run_stream(1'b0, 0, 1'b0);
    check(ess_seen == 1, "R9", "essential count all-zero", ess_seen, 1);

    // all-ones stream, R2
    for (int n = 0; n < N; n++) stim[n] = 1'b1;
    run_stream(1'b0, 5, 1'b0);
    check(ess_seen == 1, "R2", "essential count all-ones", ess_seen, 1);

    // row 1: alternating every sample, R3
    for (int n = 0; n < N; n++) stim[n] = n[0];
    run_stream(1'b1, 0, 1'b0);
    check(ess_seen == 1, "R3", "essential count row1", ess_seen, 1);

    // row 2: alternating every two samples, R3
    for (int n = 0; n < N; n++) stim[n] = n[1];
    run_stream(1'b0, 3, 1'b1);
    check(ess_seen == 1, "R3", "essential count row2", ess_seen, 1);

    // row 5, R3
    for (int n = 0; n < N; n++) stim[n] = ($countones(n & 5) % 2) == 1;
    run_stream(1'b1, 0, 1'b0);
    check(ess_seen == 1, "R3", "essential count row5", ess_seen, 1);

    // random streams, surplus bits and stray starts, R4/R5
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < N; n++) stim[n] = $urandom_range(0, 1);
      run_stream(r[0], 20, 1'b1);
    end

    // sparse stream: few ones gives mid-size coefficients near threshold, R5
    for (int n = 0; n < N; n++) stim[n] = (n % 11 == 0) || (n % 13 == 0);
    run_stream(1'b0, 0, 1'b0);

    check(done_seen == 10, "R7", "done pulse count", done_seen, 10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(2.0 * HALF * 200000);
    errors++;
    checks++;
    $display("FAIL R7 global watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule